// File: doc/BRIEF.md
# Sample Playback Voice

This block is one playback channel for a sound engine. It reads bytes from an external sample memory and turns them into a signed output sample scaled by a channel volume. A 12-bit pitch value feeds a fractional step counter, so the voice advances through memory at a rate that is a fraction of the tick rate. Each byte is played in one of two formats. In PCM format a byte is one signed 8-bit sample. In ADPCM format a byte holds two 4-bit codes, and each code adds a signed delta to a running 16-bit accumulator.

Playback can walk memory upward or downward. At the end of the programmed length the voice either stops or returns to its start address. A key-on strobe starts playback and a key-off strobe silences it. The configuration inputs are register values held by the surrounding logic. Panning and the summing of several voices belong to the parent design.

Top module: `sample_voice`

## Requirements
- R1: After reset, `busy` is 0, `sample_out` is 0 and `mem_rd_en` stays low until a key-on.
- R2: Key-on sets `busy`, loads the step counter with `cfg_pitch`, loads the address from `cfg_start` and the remaining count from `cfg_length`, and clears the held byte and the accumulator. On each cycle with `tick_en` high while busy, the counter gains 1. A tick that brings it to 0x1000 or more performs one step and sets the counter to (counter − 0x1000 + pitch). With pitch 0xFFC, the first read therefore comes on the 4th tick.
- R3: Each step reads one byte at the current address (`mem_rd_en` high, `mem_rd_addr` valid in that cycle, `mem_rd_data` used one cycle later). The address moves by +1, or by −1 when `cfg_reverse` is 1, with wraparound at 21 bits.
- R4: A 4-bit sub-byte position starts at 4. It gains 8 only when it is below 8, which is the only time the address moves. A step then lowers it by 4 in ADPCM or by 8 in PCM. In ADPCM this gives two codes per byte: going forward, bits 3:0 come first and bits 7:4 second; in reverse, bits 7:4 come first.
- R5: In ADPCM, each nonzero code adds its entry from the 16-entry signed delta table (codes 1..7 give +1,+2,+4,...,+64; codes 8..15 give −128,−64,...,−1) to the 16-bit accumulator, which wraps. A code of 0 leaves the accumulator unchanged.
- R6: In PCM, the output base is the held byte, sign-extended. Because the address moves before the first fetch, the first byte played is at start±1.
- R7: Each address move lowers the remaining count by one. When it drops below zero with `cfg_loop` 0, `busy` clears and the output becomes 0. A length of L therefore allows L+1 moves.
- R8: When the count drops below zero with `cfg_loop` 1, the address returns to `cfg_start`, the count to `cfg_length` and the accumulator to 0, and the step reads the byte at `cfg_start`. `busy` stays 1.
- R9: `sample_out` equals the base (accumulator in ADPCM, signed byte in PCM) times the unsigned 7-bit `cfg_volume`. It is 0 whenever `busy` is 0.
- R10: Key-off clears `busy` and silences the output on the next cycle. When key-on and key-off arrive in the same cycle, key-on wins.
- R11: With `tick_en` low, the counter, address and output hold and no memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances the step counter by one |
| key_on | input | 1 | Start playback strobe |
| key_off | input | 1 | Stop playback strobe |
| cfg_pitch | input | 12 | Step counter reload increment |
| cfg_length | input | 16 | Byte moves allowed minus one |
| cfg_start | input | 21 | First address / loop address |
| cfg_volume | input | 7 | Unsigned output gain |
| cfg_adpcm | input | 1 | 1: nibble delta format, 0: signed byte format |
| cfg_reverse | input | 1 | 1: address moves downward |
| cfg_loop | input | 1 | 1: return to start at end |
| mem_rd_en | output | 1 | Sample memory read strobe |
| mem_rd_addr | output | 21 | Sample memory read address |
| mem_rd_data | input | 8 | Byte returned one cycle after the strobe |
| sample_out | output | 23 | Signed volume-scaled sample |
| busy | output | 1 | Voice is playing |

## Verification
The bench builds the voice with its default parameters: a 12-bit pitch, a 21-bit address, a 16-bit accumulator, a tick increment of 1 and the default delta table. An increment of 1 lets a pitch of 0xFFF produce a step on every tick. That brings back-to-back steps within reach, where a loop restart clears the accumulator in the same cycle that an earlier fetch would add to it. It also lets small pitch values spread steps thousands of ticks apart, and with the full 21-bit address a reverse start at 0 wraps to the top of memory.

// File: rtl/voice_pkg.sv
package voice_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;
   localparam int unsigned POS_W  = 4;

   // sub-byte position constants
   localparam logic [POS_W-1:0] POS_INIT = 4'd4;
   localparam logic [POS_W-1:0] POS_HALF = 4'd8;

   // default signed delta per 4-bit code, index 15 on the left
   localparam logic [15:0][7:0] VOICE_DELTA_LUT = {
      8'hFF, 8'hFE, 8'hFC, 8'hF8, 8'hF0, 8'hE0, 8'hC0, 8'h80,
      8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01, 8'h00
   };

   typedef struct packed {
      logic adpcm;
      logic reverse;
      logic loop;
   } voice_mode_t;

endpackage

// File: rtl/voice_rate.sv
module voice_rate #(
   parameter int unsigned PITCH_W  = 12,
   parameter int unsigned STEP_INC = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               active,
   input  logic               tick_en,
   input  logic [PITCH_W-1:0] pitch,
   output logic               step
);
   localparam int unsigned CNT_W = PITCH_W + 2;
   localparam logic [CNT_W-1:0] WRAP = CNT_W'(1) << PITCH_W;
   localparam logic [CNT_W-1:0] INC  = CNT_W'(STEP_INC);

   if (STEP_INC < 1 || STEP_INC > (1 << PITCH_W)) begin : g_bad_inc
      $error("voice_rate: STEP_INC must lie in 1 .. 2**PITCH_W");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] sum;
   logic [CNT_W-1:0] pitch_x;

   assign pitch_x = CNT_W'(pitch);
   assign sum     = cnt + INC;
   assign step    = active && tick_en && (sum >= WRAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= pitch_x;
      end else if (active && tick_en) begin
         cnt <= step ? (sum - WRAP + pitch_x) : sum;
      end
   end

   // R11: without a tick or a restart the counter holds
   p_idle_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !restart) |=> $stable(cnt));

   // R2: the counter never runs past twice the step threshold
   p_cnt_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt < (WRAP << 1));

endmodule

// File: rtl/voice_walker.sv
module voice_walker
   import voice_pkg::*;
#(
   parameter int unsigned ADDR_W = 21,
   parameter int unsigned LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_on,
   input  logic              key_off,
   input  logic              step,
   input  logic [ADDR_W-1:0] cfg_start,
   input  logic [LEN_W-1:0]  cfg_length,
   input  voice_mode_t       mode,
   output logic              busy,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              nib_hi,
   output logic              acc_clear
);
   localparam int unsigned REM_W = LEN_W + 1;

   logic              enable;
   logic [ADDR_W-1:0] addr;
   logic [REM_W-1:0]  remain;
   logic [POS_W-1:0]  pos;

   logic              fire;
   logic              moved;
   logic [POS_W-1:0]  pos_up;
   logic [POS_W-1:0]  pos_next;
   logic [ADDR_W-1:0] addr_mv;
   logic [REM_W-1:0]  remain_dec;
   logic              ended;
   logic              reload;
   logic [ADDR_W-1:0] addr_next;
   logic [REM_W-1:0]  remain_next;

   assign fire       = step && !key_on && !key_off;
   assign moved      = pos < POS_HALF;
   assign pos_up     = moved ? (pos + POS_HALF) : pos;
   assign pos_next   = pos_up - (mode.adpcm ? POS_INIT : POS_HALF);
   assign addr_mv    = mode.reverse ? (addr - ADDR_W'(1)) : (addr + ADDR_W'(1));
   assign remain_dec = remain - REM_W'(1);
   assign ended      = moved && remain_dec[REM_W-1];
   assign reload     = ended && mode.loop;

   always_comb begin
      addr_next   = addr;
      remain_next = remain;
      if (moved) begin
         addr_next   = reload ? cfg_start : addr_mv;
         remain_next = reload ? REM_W'(cfg_length) : remain_dec;
      end
   end

   assign rd_en     = fire;
   assign rd_addr   = addr_next;
   assign nib_hi    = mode.adpcm && (mode.reverse ? !pos_next[2] : pos_next[2]);
   assign acc_clear = fire && reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         busy   <= 1'b0;
         addr   <= '0;
         remain <= '0;
         pos    <= POS_INIT;
      end else if (key_on) begin
         enable <= 1'b1;
         busy   <= 1'b1;
         addr   <= cfg_start;
         remain <= REM_W'(cfg_length);
         pos    <= POS_INIT;
      end else if (key_off) begin
         enable <= 1'b0;
         busy   <= 1'b0;
      end else if (fire) begin
         addr   <= addr_next;
         remain <= remain_next;
         pos    <= pos_next;
         if (ended && !mode.loop) begin
            busy <= 1'b0;
         end
      end
   end

   // R10: playing implies the voice is keyed on
   p_busy_enabled_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> enable);

   // R4: the sub-byte position only ever takes the values 4, 8 or 12
   p_pos_legal_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (pos == 4'd4) || (pos == 4'd8) || (pos == 4'd12));

   // R2: key-on loads the start address and starts playback
   p_keyon_load_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      key_on |=> (busy && addr == $past(cfg_start)));

   // R3: a read without a loop restart lands within one byte of the held address
   p_addr_near_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !acc_clear) |->
         (rd_addr == addr) || (rd_addr == addr + ADDR_W'(1)) || (rd_addr == addr - ADDR_W'(1)));

   // R1: no read is issued while idle
   p_idle_no_read_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_en);

endmodule

// File: rtl/voice_decoder.sv
module voice_decoder
   import voice_pkg::*;
#(
   parameter int unsigned ACC_W   = 16,
   parameter int unsigned DELTA_W = 8,
   parameter logic [15:0][DELTA_W-1:0] DELTA_LUT = VOICE_DELTA_LUT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    restart,
   input  logic                    acc_clear,
   input  logic                    rd_en,
   input  logic                    nib_hi,
   input  logic                    adpcm,
   input  logic [BYTE_W-1:0]       rd_data,
   output logic signed [ACC_W-1:0] base
);
   if (ACC_W <= BYTE_W) begin : g_bad_acc
      $error("voice_decoder: ACC_W must exceed the byte width");
   end
   if (DELTA_W > ACC_W) begin : g_bad_delta
      $error("voice_decoder: DELTA_W must not exceed ACC_W");
   end

   logic                    pend;
   logic                    pend_hi;
   logic                    pend_adpcm;
   logic [BYTE_W-1:0]       data_q;
   logic signed [ACC_W-1:0] acc;
   logic [NIB_W-1:0]        nib;
   logic [DELTA_W-1:0]      delta_raw;
   logic [ACC_W-1:0]        delta_x;
   logic [ACC_W-1:0]        pcm_x;

   assign nib       = pend_hi ? rd_data[7:4] : rd_data[3:0];
   assign delta_raw = DELTA_LUT[nib];

   if (DELTA_W == ACC_W) begin : g_delta_full
      assign delta_x = delta_raw;
   end else begin : g_delta_ext
      assign delta_x = {{(ACC_W-DELTA_W){delta_raw[DELTA_W-1]}}, delta_raw};
   end

   assign pcm_x = {{(ACC_W-BYTE_W){data_q[BYTE_W-1]}}, data_q};
   assign base  = adpcm ? acc : $signed(pcm_x);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         pend_hi    <= 1'b0;
         pend_adpcm <= 1'b0;
         data_q     <= '0;
         acc        <= '0;
      end else if (restart) begin
         pend       <= 1'b0;
         pend_hi    <= 1'b0;
         pend_adpcm <= 1'b0;
         data_q     <= '0;
         acc        <= '0;
      end else begin
         pend       <= rd_en;
         pend_hi    <= nib_hi;
         pend_adpcm <= adpcm;
         if (pend) begin
            data_q <= rd_data;
         end
         if (acc_clear) begin
            acc <= '0;
         end else if (pend && pend_adpcm && (nib != '0)) begin
            acc <= acc + $signed(delta_x);
         end
      end
   end

   // R5: a zero code leaves the accumulator untouched
   p_zero_code_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (pend && nib == '0 && !acc_clear && !restart) |=> $stable(acc));

   // R8: a loop restart empties the accumulator
   p_loop_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clear && !restart) |=> (acc == '0));

endmodule

// File: rtl/voice_scale.sv
module voice_scale #(
   parameter int unsigned ACC_W = 16,
   parameter int unsigned VOL_W = 7
) (
   input  logic signed [ACC_W-1:0]       base,
   input  logic        [VOL_W-1:0]       volume,
   input  logic                          active,
   output logic signed [ACC_W+VOL_W-1:0] scaled
);
   localparam int unsigned OUT_W = ACC_W + VOL_W;

   logic signed [VOL_W:0] vol_s;
   logic signed [OUT_W:0] prod;

   assign vol_s  = {1'b0, volume};
   assign prod   = (OUT_W+1)'(base) * (OUT_W+1)'(vol_s);
   assign scaled = active ? prod[OUT_W-1:0] : '0;

   // R9: a zero volume always gives silence
   always_comb begin
      if (volume == '0) begin
         a_zero_vol_r9 : assert (scaled == '0);
      end
   end

endmodule

// File: rtl/sample_voice.sv
module sample_voice
   import voice_pkg::*;
#(
   parameter int unsigned PITCH_W  = 12,
   parameter int unsigned LEN_W    = 16,
   parameter int unsigned ADDR_W   = 21,
   parameter int unsigned VOL_W    = 7,
   parameter int unsigned ACC_W    = 16,
   parameter int unsigned DELTA_W  = 8,
   parameter int unsigned STEP_INC = 1,
   parameter logic [15:0][DELTA_W-1:0] DELTA_LUT = VOICE_DELTA_LUT,
   localparam int unsigned OUT_W   = ACC_W + VOL_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_en,
   input  logic                    key_on,
   input  logic                    key_off,
   input  logic [PITCH_W-1:0]      cfg_pitch,
   input  logic [LEN_W-1:0]        cfg_length,
   input  logic [ADDR_W-1:0]       cfg_start,
   input  logic [VOL_W-1:0]        cfg_volume,
   input  logic                    cfg_adpcm,
   input  logic                    cfg_reverse,
   input  logic                    cfg_loop,
   output logic                    mem_rd_en,
   output logic [ADDR_W-1:0]       mem_rd_addr,
   input  logic [BYTE_W-1:0]       mem_rd_data,
   output logic signed [OUT_W-1:0] sample_out,
   output logic                    busy
);
   if (PITCH_W < 2 || LEN_W < 1 || ADDR_W < 1 || VOL_W < 1) begin : g_bad_widths
      $error("sample_voice: field widths too small");
   end

   voice_mode_t             mode;
   logic                    step;
   logic                    nib_hi;
   logic                    acc_clear;
   logic signed [ACC_W-1:0] base;

   assign mode = '{adpcm: cfg_adpcm, reverse: cfg_reverse, loop: cfg_loop};

   voice_rate #(
      .PITCH_W  (PITCH_W),
      .STEP_INC (STEP_INC)
   ) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (key_on),
      .active  (busy),
      .tick_en (tick_en),
      .pitch   (cfg_pitch),
      .step    (step)
   );

   voice_walker #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .key_on     (key_on),
      .key_off    (key_off),
      .step       (step),
      .cfg_start  (cfg_start),
      .cfg_length (cfg_length),
      .mode       (mode),
      .busy       (busy),
      .rd_en      (mem_rd_en),
      .rd_addr    (mem_rd_addr),
      .nib_hi     (nib_hi),
      .acc_clear  (acc_clear)
   );

   voice_decoder #(
      .ACC_W     (ACC_W),
      .DELTA_W   (DELTA_W),
      .DELTA_LUT (DELTA_LUT)
   ) u_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (key_on),
      .acc_clear (acc_clear),
      .rd_en     (mem_rd_en),
      .nib_hi    (nib_hi),
      .adpcm     (cfg_adpcm),
      .rd_data   (mem_rd_data),
      .base      (base)
   );

   voice_scale #(
      .ACC_W (ACC_W),
      .VOL_W (VOL_W)
   ) u_scale (
      .base   (base),
      .volume (cfg_volume),
      .active (busy),
      .scaled (sample_out)
   );

   // R10: key-off alone silences the voice on the next cycle
   p_keyoff_silent_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (key_off && !key_on) |=> (!busy && sample_out == '0));

endmodule

// File: tb/sample_voice_test.sv
`timescale 1ns/1ps
module sample_voice_test;

   typedef struct packed {
      logic        adpcm;
      logic        rev;
      logic        lp;
      logic [11:0] pitch;
      logic [15:0] len;
      logic [20:0] start;
      logic [6:0]  vol;
      logic [15:0] ticks;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 1'b0, 12'hFFF, 16'd5,    21'h000100, 7'd127, 16'd3},
      '{1'b0, 1'b0, 1'b0, 12'hFFF, 16'd2,    21'h000100, 7'd127, 16'd10},
      '{1'b1, 1'b0, 1'b1, 12'hFFF, 16'd3,    21'h000040, 7'd3,   16'd20},
      '{1'b1, 1'b1, 1'b1, 12'hFFC, 16'd4,    21'h0001F0, 7'd5,   16'd60},
      '{1'b0, 1'b1, 1'b1, 12'hFFE, 16'd1,    21'h000003, 7'd64,  16'd9},
      '{1'b1, 1'b0, 1'b0, 12'hFFF, 16'd40,   21'h012345, 7'd127, 16'd70},
      '{1'b0, 1'b0, 1'b1, 12'h800, 16'd3,    21'h1FFFFE, 7'd1,   16'd9000},
      '{1'b1, 1'b1, 1'b0, 12'hFFF, 16'd1000, 21'h0000A0, 7'd127, 16'd1500}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        key_on = 1'b0;
   logic        key_off = 1'b0;
   logic [11:0] cfg_pitch = '0;
   logic [15:0] cfg_length = '0;
   logic [20:0] cfg_start = '0;
   logic [6:0]  cfg_volume = '0;
   logic        cfg_adpcm = 1'b0;
   logic        cfg_reverse = 1'b0;
   logic        cfg_loop = 1'b0;
   logic        mem_rd_en;
   logic [20:0] mem_rd_addr;
   logic [7:0]  mem_rd_data;
   logic signed [22:0] sample_out;
   logic        busy;

   int          n_checks = 0;
   int          n_fail = 0;
   int          rd_count = 0;
   logic [20:0] last_addr = '0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   sample_voice uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .key_on      (key_on),
      .key_off     (key_off),
      .cfg_pitch   (cfg_pitch),
      .cfg_length  (cfg_length),
      .cfg_start   (cfg_start),
      .cfg_volume  (cfg_volume),
      .cfg_adpcm   (cfg_adpcm),
      .cfg_reverse (cfg_reverse),
      .cfg_loop    (cfg_loop),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .sample_out  (sample_out),
      .busy        (busy)
   );

   function automatic logic [7:0] mem_byte(logic [20:0] a);
      return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]};
   endfunction

   // synchronous sample memory, one cycle of latency
   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= mem_byte(mem_rd_addr);
         last_addr   <= mem_rd_addr;
         rd_count    <= rd_count + 1;
      end
   end

   function automatic int delta_of(int code);
      if (code == 0) return 0;
      if (code < 8) return 1 << (code - 1);
      return -(1 << (15 - code));
   endfunction

   // step-level model of the playback rules
   task automatic model(input vec_t v, output int exp_smp, output int exp_busy);
      int          cnt = int'(v.pitch);
      int          rem = int'(v.len);
      int          pos = 4;
      logic [20:0] addr = v.start;
      logic [7:0]  data = '0;
      logic signed [15:0] acc = '0;
      int          bsy = 1;
      for (int t = 0; t < int'(v.ticks); t++) begin
         if (bsy != 0) begin
            cnt = cnt + 1;
            if (cnt >= 4096) begin
               if (pos < 8) begin
                  pos  = pos + 8;
                  addr = v.rev ? addr - 21'd1 : addr + 21'd1;
                  rem  = rem - 1;
                  if (rem < 0) begin
                     if (v.lp) begin
                        addr = v.start;
                        rem  = int'(v.len);
                        acc  = '0;
                     end else begin
                        bsy = 0;
                     end
                  end
               end
               data = mem_byte(addr);
               if (v.adpcm) begin
                  int code;
                  bit hi;
                  pos  = pos - 4;
                  hi   = v.rev ? ((pos & 4) == 0) : ((pos & 4) != 0);
                  code = hi ? int'(data[7:4]) : int'(data[3:0]);
                  if (code != 0) acc = acc + 16'(delta_of(code));
               end else begin
                  pos = pos - 8;
               end
               cnt = cnt - 4096 + int'(v.pitch);
            end
         end
      end
      exp_busy = bsy;
      if (bsy == 0) exp_smp = 0;
      else exp_smp = (v.adpcm ? int'(acc) : int'($signed(data))) * int'(v.vol);
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic configure(input logic adp, input logic rev, input logic lp,
                            input logic [11:0] p, input logic [15:0] l,
                            input logic [20:0] s, input logic [6:0] vol);
      cfg_adpcm = adp; cfg_reverse = rev; cfg_loop = lp;
      cfg_pitch = p; cfg_length = l; cfg_start = s; cfg_volume = vol;
   endtask

   task automatic pulse_on();
      key_on = 1'b1;
      @(negedge clk);
      key_on = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int base_rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", "busy", int'(busy), 0);
      check("R1", "sample", int'(sample_out), 0);
      check("R1", "reads", rd_count, 0);

      // vector table against the model
      for (int i = 0; i < NVEC; i++) begin
         int es, eb;
         configure(VECS[i].adpcm, VECS[i].rev, VECS[i].lp, VECS[i].pitch,
                   VECS[i].len, VECS[i].start, VECS[i].vol);
         pulse_on();
         run_ticks(int'(VECS[i].ticks));
         model(VECS[i], es, eb);
         check("R9", $sformatf("vector %0d sample", i), int'(sample_out), es);
         check("R7", $sformatf("vector %0d busy", i), int'(busy), eb);
      end

      // R11 and R2: tick gating and step timing with pitch 0xFFC
      configure(1'b0, 1'b0, 1'b0, 12'hFFC, 16'd10, 21'h00007F, 7'd127);
      pulse_on();
      base_rd = rd_count;
      repeat (5) @(negedge clk);
      check("R11", "reads without tick", rd_count - base_rd, 0);
      check("R2", "busy after key-on", int'(busy), 1);
      run_ticks(3);
      check("R2", "reads after 3 ticks", rd_count - base_rd, 0);
      run_ticks(1);
      check("R2", "reads after 4 ticks", rd_count - base_rd, 1);
      check("R6", "first address", int'(last_addr), 'h80);
      check("R6", "signed byte sample", int'(sample_out), -16256);

      // R4: forward order, low code first then high code of the same byte
      configure(1'b1, 1'b0, 1'b0, 12'hFFF, 16'd10, 21'h000022, 7'd1);
      pulse_on();
      run_ticks(1);
      check("R4", "forward first code", int'(sample_out), 4);
      base_rd = rd_count;
      run_ticks(1);
      check("R4", "forward second code", int'(sample_out), 6);
      check("R4", "same byte reread", int'(last_addr), 'h23);
      check("R4", "one read per step", rd_count - base_rd, 1);

      // R4: reverse takes the high code first
      configure(1'b1, 1'b1, 1'b0, 12'hFFF, 16'd10, 21'h000024, 7'd1);
      pulse_on();
      run_ticks(1);
      check("R4", "reverse first code", int'(sample_out), 2);

      // R5: zero code holds the accumulator
      configure(1'b1, 1'b0, 1'b0, 12'hFFF, 16'd10, 21'h00001F, 7'd1);
      pulse_on();
      run_ticks(1);
      check("R5", "zero code", int'(sample_out), 0);
      check("R5", "busy during zero code", int'(busy), 1);
      run_ticks(1);
      check("R5", "next code", int'(sample_out), 2);

      // R3: reverse from address 0 wraps to the top
      configure(1'b0, 1'b1, 1'b0, 12'hFFF, 16'd10, 21'h000000, 7'd1);
      pulse_on();
      run_ticks(1);
      check("R3", "wrapped address", int'(last_addr), 'h1FFFFF);
      check("R3", "wrapped byte", int'(sample_out), 31);

      // R7: one-shot end with length 2
      configure(1'b0, 1'b0, 1'b0, 12'hFFF, 16'd2, 21'h000010, 7'd1);
      pulse_on();
      run_ticks(2);
      check("R7", "busy before end", int'(busy), 1);
      run_ticks(1);
      check("R7", "busy at end", int'(busy), 0);
      check("R7", "silent at end", int'(sample_out), 0);

      // R8: PCM loop returns to the start byte
      configure(1'b0, 1'b0, 1'b1, 12'hFFF, 16'd0, 21'h000050, 7'd1);
      pulse_on();
      run_ticks(1);
      check("R8", "loop address", int'(last_addr), 'h50);
      check("R8", "loop byte", int'(sample_out), 80);
      check("R8", "busy after loop", int'(busy), 1);

      // R8: ADPCM loop clears the accumulator on back-to-back steps
      configure(1'b1, 1'b0, 1'b1, 12'hFFF, 16'd0, 21'h000022, 7'd1);
      pulse_on();
      run_ticks(3);
      check("R8", "accumulator cleared", int'(sample_out), 2);

      // R9: zero volume silences a playing voice
      configure(1'b0, 1'b0, 1'b0, 12'hFFF, 16'd10, 21'h00007F, 7'd0);
      pulse_on();
      run_ticks(1);
      check("R9", "zero volume", int'(sample_out), 0);

      // R10: key-off silences, key-on wins over key-off
      configure(1'b0, 1'b0, 1'b0, 12'hFFF, 16'd10, 21'h00007F, 7'd2);
      pulse_on();
      run_ticks(1);
      check("R10", "playing before key-off", int'(sample_out), -256);
      key_off = 1'b1;
      @(negedge clk);
      key_off = 1'b0;
      check("R10", "busy after key-off", int'(busy), 0);
      check("R10", "sample after key-off", int'(sample_out), 0);
      key_on = 1'b1;
      key_off = 1'b1;
      @(negedge clk);
      key_on = 1'b0;
      key_off = 1'b0;
      check("R10", "key-on priority", int'(busy), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule